// File: doc/BRIEF.md
# Multi-Core Reset Controller

This block is a small register file that manages reset for a cluster of processor cores. Software uses a simple single-beat read/write bus to do four things. It can hold any core in reset or release it. It can see which cores have gone through reset since it last looked. It can cut the system-interface path of each secondary core and then wait until the cut has settled. It can also fire a one-shot request for a whole-system reset.

The block also stores a boot code word and one start vector per core. It keeps a shared message word that cores use to signal each other. Two alias addresses let any agent set or clear single bits of that word without a read-modify-write sequence. The reset outputs and interface-disable outputs go to the cores and to the fabric next to them.

Top module: `rstctl_unit`

## Requirements
- R1: After reset every output is low. Reads of the system control, core hold, in-reset status, interface-off, interface-off status, boot code and message word registers all return zero.
- R2: A write to offset 0x00 with bit 0 set raises `sys_reset_pulse` for exactly the one cycle after the write edge. Offset 0x00 always reads as zero.
- R3: Offset 0x08 holds one bit per core. Bit n drives `core_hold[n]` from the write edge on and reads back as written.
- R4: Bit n of offset 0x0C sets on the edge after `core_hold[n]` is seen high. It stays set after the hold is released. Writing a one clears it, but if the core is still held in that cycle, the set wins.
- R5: Offset 0x1C holds one bit per secondary core. Bit n-1 drives `core_if_off[n-1]`, which cuts the interface of core n, from the write edge on.
- R6: Bit n-1 of offset 0x20 follows bit n-1 of offset 0x1C with a delay of DRAIN_CYC clocks (8 by default).
- R7: The boot code at 0x28 and the start vectors at 0x2C, 0x30 and 0x34 (cores 0, 1, 2) can be written and read as full words. The start vectors keep their value through a reset.
- R8: The message word sits at 0x6C. A write there replaces it, a write to 0x70 ORs the data into it, and a write to 0x74 clears every bit written as one. Both aliases read back the word. By convention, bits 8 to 10 are the idle flags of cores 0 to 2, bits 12 to 14 are their reset requests, and bits 19 and 20 are the activated flags of cores 1 and 2.
- R9: Any other offset reads as zero, and a write to it changes no register. This includes 0x04, unmapped offsets and unaligned offsets.
- R10: Read data is registered. `bus_rdata` takes the value of the addressed register on the edge of a read access and holds it through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sys_reset_pulse | output | 1 | One-cycle system reset request |
| core_hold | output | NUM_CORES | Per-core reset hold |
| core_if_off | output | NUM_CORES-1 | Interface cut for cores 1 and up |

## Verification
The hold, interface-off and message registers change on the write edge, and the reset pulse is visible during the cycle that follows that edge. In-reset status sets one edge later. Read data appears on the edge of the read. The bench drives inputs on falling edges and samples on falling edges. It leaves one idle cycle after every write, so any read it issues is captured at least two edges after the write.

The interface-off status is checked with back-to-back reads that start right after the write. These reads must return the old value for edges one to eight after the write and the new value from edge nine on. Random traffic waits ten cycles after any write to the interface-off register before it reads again.

// File: rtl/rstctl_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the reset controller: register byte offsets and
// the decoded register identifier. Offsets form the software-visible map.
package rstctl_pkg;

    localparam int OFS_SYSCTL  = 'h00;
    localparam int OFS_HOLD    = 'h08;
    localparam int OFS_INRST   = 'h0C;
    localparam int OFS_IFOFF   = 'h1C;
    localparam int OFS_IFST    = 'h20;
    localparam int OFS_BOOT    = 'h28;
    localparam int OFS_VEC0    = 'h2C;
    localparam int OFS_MBX     = 'h6C;
    localparam int OFS_MBX_OR  = 'h70;
    localparam int OFS_MBX_AND = 'h74;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_SYSCTL,
        RID_HOLD,
        RID_INRST,
        RID_IFOFF,
        RID_IFST,
        RID_BOOT,
        RID_VEC,
        RID_MBX,
        RID_MBX_OR,
        RID_MBX_AND
    } reg_id_e;

endpackage

// File: rtl/rstctl_bus_decode.sv
`timescale 1ns/1ps
// Address decoder. Maps a byte offset to a register identifier plus a
// one-hot start-vector select. Assumes full-address compare: unaligned or
// unmapped offsets decode to RID_NONE.
module rstctl_bus_decode
    import rstctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_VEC = 3
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    output reg_id_e            reg_id,
    output logic [NUM_VEC-1:0] vec_hit
);

    // Compare the offset against each mapped register.
    always_comb begin
        reg_id  = RID_NONE;
        vec_hit = '0;
        if      (bus_addr == ADDR_W'(OFS_SYSCTL))  reg_id = RID_SYSCTL;
        else if (bus_addr == ADDR_W'(OFS_HOLD))    reg_id = RID_HOLD;
        else if (bus_addr == ADDR_W'(OFS_INRST))   reg_id = RID_INRST;
        else if (bus_addr == ADDR_W'(OFS_IFOFF))   reg_id = RID_IFOFF;
        else if (bus_addr == ADDR_W'(OFS_IFST))    reg_id = RID_IFST;
        else if (bus_addr == ADDR_W'(OFS_BOOT))    reg_id = RID_BOOT;
        else if (bus_addr == ADDR_W'(OFS_MBX))     reg_id = RID_MBX;
        else if (bus_addr == ADDR_W'(OFS_MBX_OR))  reg_id = RID_MBX_OR;
        else if (bus_addr == ADDR_W'(OFS_MBX_AND)) reg_id = RID_MBX_AND;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (bus_addr == ADDR_W'(OFS_VEC0 + 4 * i)) begin
                reg_id     = RID_VEC;
                vec_hit[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rstctl_core_slice.sv
`timescale 1ns/1ps
// Per-core reset hold bit and its sticky in-reset status. The status sets
// one edge after the hold output is high; a write-one clear loses against a
// hold that is still active.
module rstctl_core_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_we,
    input  logic hold_d,
    input  logic clr_we,
    input  logic clr_d,
    output logic hold_o,
    output logic inrst_o
);

    // Hold register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_o <= 1'b0;
        else if (hold_we) hold_o <= hold_d;
    end

    // Sticky status: set by an active hold, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                inrst_o <= 1'b0;
        else if (hold_o)           inrst_o <= 1'b1;
        else if (clr_we && clr_d)  inrst_o <= 1'b0;
    end

endmodule

// File: rtl/rstctl_if_drain.sv
`timescale 1ns/1ps
// Interface-off control for one secondary core. The status output is the
// control bit delayed by DRAIN_CYC clocks, standing in for the time the
// fabric needs to drain. Assumes DRAIN_CYC >= 2.
module rstctl_if_drain #(
    parameter int DRAIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_we,
    input  logic off_d,
    output logic off_o,
    output logic off_st_o
);

    logic [DRAIN_CYC-1:0] line_q;

    // Control bit written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      off_o <= 1'b0;
        else if (off_we) off_o <= off_d;
    end

    // Fixed-length delay line toward the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= {line_q[DRAIN_CYC-2:0], off_o};
    end

    assign off_st_o = line_q[DRAIN_CYC-1];

endmodule

// File: rtl/rstctl_mailbox.sv
`timescale 1ns/1ps
// Shared message word with a plain write port and two atomic alias ports
// (OR-in and clear-ones). Assumes at most one port is strobed per cycle.
module rstctl_mailbox #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_full,
    input  logic              wr_or,
    input  logic              wr_andn,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word_o
);

    // Apply whichever update port is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_o <= '0;
        else if (wr_full) word_o <= wdata;
        else if (wr_or)   word_o <= word_o | wdata;
        else if (wr_andn) word_o <= word_o & ~wdata;
    end

endmodule

// File: rtl/rstctl_unit.sv
`timescale 1ns/1ps
// Reset controller top. Decodes single-cycle bus accesses, owns the
// system reset pulse, boot code, start vectors and read mux, and instances
// one slice per core plus one drain stage per secondary core. Start vectors
// are deliberately left out of reset so a programmed entry point survives.
module rstctl_unit
    import rstctl_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int DRAIN_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 sys_reset_pulse,
    output logic [NUM_CORES-1:0] core_hold,
    output logic [NUM_CORES-2:0] core_if_off
);

    localparam int NUM_SEC = NUM_CORES - 1;

    reg_id_e              rid;
    logic [NUM_CORES-1:0] vec_hit;
    logic                 wr_go;
    logic                 rd_go;
    logic [NUM_CORES-1:0] inrst_q;
    logic [NUM_SEC-1:0]   ifst_q;
    logic [DATA_W-1:0]    boot_q;
    logic [DATA_W-1:0]    vec_q [NUM_CORES];
    logic [DATA_W-1:0]    mbx_q;
    logic [DATA_W-1:0]    rd_val;

    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & ~bus_wr;

    rstctl_bus_decode #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_CORES)) u_dec (
        .bus_addr (bus_addr),
        .reg_id   (rid),
        .vec_hit  (vec_hit)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        rstctl_core_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_we (wr_go && rid == RID_HOLD),
            .hold_d  (bus_wdata[c]),
            .clr_we  (wr_go && rid == RID_INRST),
            .clr_d   (bus_wdata[c]),
            .hold_o  (core_hold[c]),
            .inrst_o (inrst_q[c])
        );
    end

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        rstctl_if_drain #(.DRAIN_CYC(DRAIN_CYC)) u_drain (
            .clk      (clk),
            .rst_n    (rst_n),
            .off_we   (wr_go && rid == RID_IFOFF),
            .off_d    (bus_wdata[s]),
            .off_o    (core_if_off[s]),
            .off_st_o (ifst_q[s])
        );
    end

    rstctl_mailbox #(.DATA_W(DATA_W)) u_mbx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (wr_go && rid == RID_MBX),
        .wr_or   (wr_go && rid == RID_MBX_OR),
        .wr_andn (wr_go && rid == RID_MBX_AND),
        .wdata   (bus_wdata),
        .word_o  (mbx_q)
    );

    // One-cycle system reset request; the control bit never stores.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_reset_pulse <= 1'b0;
        else        sys_reset_pulse <= wr_go && rid == RID_SYSCTL && bus_wdata[0];
    end

    // Boot code word.
    always_ff @(posedge clk) begin
        if (!rst_n)                       boot_q <= '0;
        else if (wr_go && rid == RID_BOOT) boot_q <= bus_wdata;
    end

    for (genvar v = 0; v < NUM_CORES; v++) begin : g_vec
        // Start vector, not cleared by reset.
        always_ff @(posedge clk) begin
            if (wr_go && vec_hit[v]) vec_q[v] <= bus_wdata;
        end
    end

    // Read mux; unmapped identifiers return zero.
    always_comb begin
        rd_val = '0;
        case (rid)
            RID_HOLD:    rd_val[NUM_CORES-1:0] = core_hold;
            RID_INRST:   rd_val[NUM_CORES-1:0] = inrst_q;
            RID_IFOFF:   rd_val[NUM_SEC-1:0]   = core_if_off;
            RID_IFST:    rd_val[NUM_SEC-1:0]   = ifst_q;
            RID_BOOT:    rd_val = boot_q;
            RID_VEC: begin
                for (int i = 0; i < NUM_CORES; i++)
                    if (vec_hit[i]) rd_val = vec_q[i];
            end
            RID_MBX, RID_MBX_OR, RID_MBX_AND: rd_val = mbx_q;
            default:     rd_val = '0;
        endcase
    end

    // Registered read data, updated only on read accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_val;
    end

endmodule

// File: rtl/rstctl_unit_chk.sv
`timescale 1ns/1ps
// Property checker for rstctl_unit, attached by bind. Observes bus ports,
// outputs, the sticky status vector and the message word.
module rstctl_unit_chk
    import rstctl_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 sys_reset_pulse,
    input logic [NUM_CORES-1:0] core_hold,
    input logic [NUM_CORES-2:0] core_if_off,
    input logic [NUM_CORES-1:0] inrst_q,
    input logic [DATA_W-1:0]    mbx_q
);

    p_pulse_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_pulse |-> $past(bus_sel && bus_wr &&
                                  bus_addr == ADDR_W'(OFS_SYSCTL) && bus_wdata[0]));

    p_hold_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_hold) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_HOLD)));

    p_inrst_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_hold) |=> ((inrst_q & $past(core_hold)) == $past(core_hold)));

    p_ifoff_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_if_off) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_IFOFF)));

    p_mbx_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_MBX_OR))
        |=> ((mbx_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && !bus_wr && bus_addr == ADDR_W'('h04)) |-> (bus_rdata == '0));

endmodule

bind rstctl_unit rstctl_unit_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .sys_reset_pulse (sys_reset_pulse),
    .core_hold       (core_hold),
    .core_if_off     (core_if_off),
    .inrst_q         (inrst_q),
    .mbx_q           (mbx_q)
);

// File: tb/rstctl_unit_bench.sv
`timescale 1ns/1ps
module rstctl_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_reset_pulse;
    logic [2:0]  core_hold;
    logic [1:0]  core_if_off;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    logic [2:0]  m_hold = '0;
    logic [2:0]  m_inrst = '0;
    logic [1:0]  m_ifoff = '0;
    logic [31:0] m_boot = '0;
    logic [31:0] m_vec [3];
    logic [31:0] m_mbx = '0;

    always #5 clk = ~clk;

    rstctl_unit u_rstctl_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_sel         (bus_sel),
        .bus_wr          (bus_wr),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .sys_reset_pulse (sys_reset_pulse),
        .core_hold       (core_hold),
        .core_if_off     (core_if_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h08: return {29'b0, m_hold};
            8'h0C: return {29'b0, m_inrst};
            8'h1C: return {30'b0, m_ifoff};
            8'h20: return {30'b0, m_ifoff};
            8'h28: return m_boot;
            8'h2C: return m_vec[0];
            8'h30: return m_vec[1];
            8'h34: return m_vec[2];
            8'h6C, 8'h70, 8'h74: return m_mbx;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h08: begin m_hold = d[2:0]; m_inrst = m_inrst | m_hold; end
            8'h0C: m_inrst = (m_inrst & ~d[2:0]) | m_hold;
            8'h1C: m_ifoff = d[1:0];
            8'h28: m_boot = d;
            8'h2C: m_vec[0] = d;
            8'h30: m_vec[1] = d;
            8'h34: m_vec[2] = d;
            8'h6C: m_mbx = d;
            8'h70: m_mbx = m_mbx | d;
            8'h74: m_mbx = m_mbx & ~d;
            default: ;
        endcase
    endfunction

    // write, then one idle cycle; ends one negedge after the edge that follows the write edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        model_wr(a, d);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp_rd(a));
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0] alist [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h1C, 8'h20, 8'h28, 8'h2C,
                                   8'h30, 8'h34, 8'h6C, 8'h70, 8'h74, 8'h10, 8'h2E, 8'h78};
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", {27'b0, sys_reset_pulse, core_hold, core_if_off}, 32'h0);
        read_chk("R1 sysctl", 8'h00);
        read_chk("R1 hold", 8'h08);
        read_chk("R1 inrst", 8'h0C);
        read_chk("R1 ifoff", 8'h1C);
        read_chk("R1 ifst", 8'h20);
        read_chk("R1 boot", 8'h28);
        read_chk("R1 mbx", 8'h6C);

        // R7 boot code and vectors
        bus_write(8'h28, 32'hB007_C0DE);
        for (int i = 0; i < 3; i++) bus_write(8'(8'h2C + 4 * i), 32'h1000_0000 + 32'(i * 'h100));
        read_chk("R7 boot", 8'h28);
        for (int i = 0; i < 3; i++) read_chk("R7 vector", 8'(8'h2C + 4 * i));

        // R2 system reset pulse
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R2 pulse high", {31'b0, sys_reset_pulse}, 32'h1);
        @(negedge clk);
        check("R2 pulse low", {31'b0, sys_reset_pulse}, 32'h0);
        read_chk("R2 ctl reads zero", 8'h00);
        bus_write(8'h00, 32'hFFFF_FFFE);
        check("R2 bit0 clear no pulse", {31'b0, sys_reset_pulse}, 32'h0);

        // R3 / R4 hold and sticky status
        bus_write(8'h08, 32'h2);
        check("R3 hold out", {29'b0, core_hold}, 32'h2);
        read_chk("R3 hold rd", 8'h08);
        read_chk("R4 inrst set", 8'h0C);
        bus_write(8'h08, 32'h0);
        read_chk("R4 inrst sticky", 8'h0C);
        bus_write(8'h0C, 32'h2);
        read_chk("R4 inrst w1c", 8'h0C);
        bus_write(8'h08, 32'h4);
        bus_write(8'h0C, 32'h4);
        read_chk("R4 set wins over clear", 8'h0C);
        bus_write(8'h08, 32'h0);
        bus_write(8'h0C, 32'h7);
        read_chk("R4 cleared", 8'h0C);

        // R5 / R6 interface cut and drain timing
        bus_write(8'h1C, 32'h1);
        check("R5 ifoff out", {30'b0, core_if_off}, 32'h1);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h20;
        for (int e = 2; e <= 10; e++) begin
            @(negedge clk);
            check($sformatf("R6 ifst edge %0d", e), bus_rdata, (e >= 9) ? 32'h1 : 32'h0);
        end
        bus_sel = 1'b0;
        read_chk("R5 ifoff rd", 8'h1C);

        // R8 message word
        bus_write(8'h6C, 32'h0000_0700);
        bus_write(8'h70, 32'h0018_0000);
        bus_write(8'h74, 32'h0000_0200);
        bus_read(8'h6C, d);
        check("R8 set/clear", d, 32'h0018_0500);
        read_chk("R8 alias read", 8'h74);

        // R9 undefined offsets
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h2E, 32'hFFFF_FFFF);
        read_chk("R9 0x04", 8'h04);
        read_chk("R9 unaligned", 8'h2E);
        read_chk("R9 vector untouched", 8'h2C);

        // R10 read data holds across a write
        bus_read(8'h28, d);
        bus_write(8'h6C, 32'h1234_5678);
        check("R10 rdata hold", bus_rdata, d);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = alist[$urandom_range(15)];
            if ($urandom_range(1) == 1) begin
                bus_write(a, $urandom());
                if (a == 8'h1C) repeat (10) @(negedge clk);
            end else begin
                read_chk($sformatf("R9/R8/R4 random rd %h", a), a);
            end
        end

        // R7 vectors survive reset, others clear (R1)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_hold = '0; m_inrst = '0; m_ifoff = '0; m_boot = '0; m_mbx = '0;
        for (int i = 0; i < 3; i++) read_chk("R7 vector after reset", 8'(8'h2C + 4 * i));
        read_chk("R1 boot after reset", 8'h28);
        read_chk("R1 mbx after reset", 8'h6C);
        check("R1 outputs after reset", {27'b0, sys_reset_pulse, core_hold, core_if_off}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule